// File: doc/BRIEF.md
# Eight-Channel Sampling Converter Serial Slave Controller

This block is the digital side of an eight-channel, 12-bit sampling converter that a host reaches over a four-wire serial port. The host lowers chip select and runs the serial clock. Each run of 16 clocks is one conversion. During the first clocks of a conversion the host shifts in a command byte, and part of that byte chooses the channel for the following conversion. At the same time the block sends out four zeros followed by the 12-bit sample, most significant bit first. The analog front end is not modelled. The twelve-bit value of each channel comes in on a parallel bus and is captured at the instant the block leaves tracking.

All pins are sampled on a fast system clock `clk`. Serial clock edges are found by comparing each sample with the one before it, so `cs_n`, `sclk` and `sdi` must already be synchronous to `clk`. The block reports which phase it is in (tracking, holding, powered down) and gives an output enable that a pad driver uses to make the serial data line high impedance.

Top module: `mux_adc_serial_if`

## Requirements
- R1: While `cs_n` stays low, conversions follow one another back to back, each exactly 16 serial clocks long. The falling edge that follows the 16th rising edge of a conversion is falling edge 1 of the next one.
- R2: `track` is high after falling edges 1, 2 and 3 of a conversion. `hold` is high from falling edge 4 up to falling edge 15, and it stays high through the rising edge that follows falling edge 15.
- R3: After falling edges 1 to 4, `sdo` is 0. After falling edges 5 to 16 it carries sample bits 11 down to 0 in turn, as plain unsigned binary.
- R4: Within each conversion, `sdi` is taken on rising edges 1 to 8, first bit as byte bit 7. Byte bits 5:3 form the channel address: value n selects `ch_data[n*12 +: 12]`. Byte bits 7, 6, 2, 1 and 0 have no effect.
- R5: An address captured during one conversion selects the channel of the next conversion, including a next conversion in a later frame. After reset, channel 0 is used.
- R6: While `cs_n` is high, `sdo_oe` is 0 and `track` and `hold` are 0, and serial clock edges are ignored. When `cs_n` falls, a new conversion always starts at falling edge 1.
- R7: If `cs_n` falls while `sclk` is low, that fall counts as falling edge 1. If `cs_n` falls while `sclk` is high, falling edge 1 is the next `sclk` fall. Until then `track`, `hold` and `pwr_down` are all 0, and `sdo` is driven as 0.
- R8: `pwr_down` is 1 while `cs_n` is high. It is also 1 from falling edge 16 of a conversion until falling edge 1 of the next one.
- R9: The selected channel's value is latched at falling edge 4. The shifted result is that latched value even if `ch_data` changes afterwards.
- R10: If `cs_n` rises before rising edge 8 of a conversion, the conversion is dropped and the channel address keeps its last fully received value.
- R11: After reset `sdo` is 0, `sdo_oe` is 0, `pwr_down` is 1, and `track` and `hold` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select framing the conversions |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial command data from the host |
| ch_data | input | 96 | Eight 12-bit channel values, channel n in bits n*12+11:n*12 |
| sdo | output | 1 | Serial result data |
| sdo_oe | output | 1 | Drive enable for the serial data pad |
| track | output | 1 | Tracking phase flag |
| hold | output | 1 | Hold/convert phase flag |
| pwr_down | output | 1 | Powered-down status |

## Verification
Single-conversion frames are compared against back-to-back frames of three conversions. A mismatch there separates a correct wrap on the 16th edge from a counter that only resets on chip select. Frames that start with the serial clock high are compared against frames that start with it low, which shows whether a chip-select fall with the clock low is counted as the first falling edge exactly once. Command bytes with every ignored bit set, a frame cut off before the eighth rising edge, and a run of clock toggles while deselected each test a different route to a wrong channel. The parallel channel values are inverted once the hold phase has begun, so that a design which picks the sample late is caught.

// File: rtl/adcs_pkg.sv
`timescale 1ns/1ps
package adcs_pkg;
   // Phase of the serial slave inside a conversion.
   typedef enum logic [1:0] {
      PH_OFF   = 2'd0,   // deselected or between conversions
      PH_WAIT  = 2'd1,   // selected, first falling edge not yet seen
      PH_TRACK = 2'd2,
      PH_HOLD  = 2'd3
   } phase_e;
endpackage

// File: rtl/adcs_edge_det.sv
`timescale 1ns/1ps
module adcs_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   output logic fall_evt,
   output logic rise_evt
);
   logic sclk_q;
   logic cs_n_q;
   logic cs_fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         cs_n_q <= 1'b1;
      end else begin
         sclk_q <= sclk;
         cs_n_q <= cs_n;
      end
   end

   assign cs_fall = cs_n_q & ~cs_n;

   // A select fall while the serial clock is low stands in for a clock fall.
   // A clock fall in the same cycle is then counted only once.
   always_comb begin
      fall_evt = 1'b0;
      if (!cs_n) begin
         if (cs_fall) fall_evt = ~sclk;
         else         fall_evt = sclk_q & ~sclk;
      end
   end

   assign rise_evt = ~cs_n & ~cs_fall & sclk & ~sclk_q;
endmodule

// File: rtl/adcs_frame_seq.sv
`timescale 1ns/1ps
module adcs_frame_seq
   import adcs_pkg::*;
#(
   parameter int FRAME_LEN = 16,
   parameter int TRACK_CYC = 3,
   localparam int IDXW = $clog2(FRAME_LEN + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_n,
   input  logic            fall_evt,
   output logic [IDXW-1:0] idx,
   output logic [IDXW-1:0] next_idx,
   output logic            hold_start,
   output phase_e          phase
);
   localparam logic [IDXW-1:0] LAST_IDX  = IDXW'(FRAME_LEN);
   localparam logic [IDXW-1:0] TRACK_END = IDXW'(TRACK_CYC);
   localparam logic [IDXW-1:0] HOLD_IDX  = IDXW'(TRACK_CYC + 1);

   // idx is the number of the latest falling edge in the current conversion.
   // 0 means the select has fallen but no falling edge has been seen yet.
   always_comb begin
      if (idx == '0 || idx == LAST_IDX) next_idx = IDXW'(1);
      else                              next_idx = idx + IDXW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        idx <= '0;
      else if (cs_n)     idx <= '0;
      else if (fall_evt) idx <= next_idx;
   end

   assign hold_start = fall_evt & (next_idx == HOLD_IDX);

   always_comb begin
      if (cs_n)                  phase = PH_OFF;
      else if (idx == '0)        phase = PH_WAIT;
      else if (idx <= TRACK_END) phase = PH_TRACK;
      else if (idx == LAST_IDX)  phase = PH_OFF;
      else                       phase = PH_HOLD;
   end
endmodule

// File: rtl/adcs_cmd_cap.sv
`timescale 1ns/1ps
module adcs_cmd_cap #(
   parameter int CMD_W    = 8,
   parameter int ADDR_W   = 3,
   parameter int ADDR_LSB = 3,
   parameter int IDXW     = 5,
   localparam int SHW = ADDR_LSB + ADDR_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rise_evt,
   input  logic              sdi,
   input  logic [IDXW-1:0]   idx,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [IDXW-1:0] CMD_LAST = IDXW'(CMD_W);

   // Keep only the low command bits. When the last command bit arrives, the
   // address field sits at the top of this register.
   logic [SHW-1:0] sh;
   logic           in_cmd;

   assign in_cmd = rise_evt && (idx != '0) && (idx <= CMD_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh   <= '0;
         addr <= '0;
      end else if (cs_n) begin
         sh <= '0;
      end else if (in_cmd) begin
         sh <= {sh[SHW-2:0], sdi};
         if (idx == CMD_LAST) addr <= sh[SHW-1 -: ADDR_W];
      end
   end
endmodule

// File: rtl/adcs_out_shift.sv
`timescale 1ns/1ps
module adcs_out_shift #(
   parameter int NUM_CH    = 8,
   parameter int SAMPLE_W  = 12,
   parameter int FRAME_LEN = 16,
   parameter int IDXW      = 5,
   parameter int ADDR_W    = 3,
   localparam int LEAD = FRAME_LEN - SAMPLE_W,
   localparam int BSW  = $clog2(FRAME_LEN)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs_n,
   input  logic                       fall_evt,
   input  logic                       hold_start,
   input  logic [IDXW-1:0]            next_idx,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [NUM_CH*SAMPLE_W-1:0] ch_data,
   output logic [SAMPLE_W-1:0]        sample_q,
   output logic                       sdo
);
   localparam logic [IDXW-1:0] LAST_IDX = IDXW'(FRAME_LEN);
   localparam logic [IDXW-1:0] LEAD_IDX = IDXW'(LEAD);

   logic [SAMPLE_W-1:0] chv [NUM_CH];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
      assign chv[g] = ch_data[g*SAMPLE_W +: SAMPLE_W];
   end

   logic [BSW-1:0] bsel;
   logic           data_bit;

   assign bsel = BSW'(LAST_IDX - next_idx);

   if (LEAD > 0) begin : g_lead
      assign data_bit = (next_idx <= LEAD_IDX) ? 1'b0 : sample_q[bsel];
   end else begin : g_nolead
      assign data_bit = sample_q[bsel];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          sample_q <= '0;
      else if (hold_start) sample_q <= chv[addr];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        sdo <= 1'b0;
      else if (cs_n)     sdo <= 1'b0;
      else if (fall_evt) sdo <= data_bit;
   end
endmodule

// File: rtl/mux_adc_serial_if.sv
`timescale 1ns/1ps
module mux_adc_serial_if
   import adcs_pkg::*;
#(
   parameter int NUM_CH    = 8,
   parameter int SAMPLE_W  = 12,
   parameter int FRAME_LEN = 16,
   parameter int TRACK_CYC = 3,
   parameter int CMD_W     = 8,
   parameter int ADDR_LSB  = 3,
   localparam int ADDR_W = $clog2(NUM_CH),
   localparam int IDXW   = $clog2(FRAME_LEN + 1),
   localparam int LEAD   = FRAME_LEN - SAMPLE_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs_n,
   input  logic                       sclk,
   input  logic                       sdi,
   input  logic [NUM_CH*SAMPLE_W-1:0] ch_data,
   output logic                       sdo,
   output logic                       sdo_oe,
   output logic                       track,
   output logic                       hold,
   output logic                       pwr_down
);
   // Elaboration-time parameter checks.
   if (NUM_CH < 2 || (1 << ADDR_W) != NUM_CH) begin : g_bad_ch
      $error("NUM_CH must be a power of two of at least 2");
   end
   if (LEAD < TRACK_CYC + 1) begin : g_bad_lead
      $error("leading zeros must cover the tracking cycles plus the hold edge");
   end
   if (TRACK_CYC < 1) begin : g_bad_track
      $error("TRACK_CYC must be at least 1");
   end
   if (CMD_W > FRAME_LEN || ADDR_LSB < 1 || ADDR_LSB + ADDR_W > CMD_W) begin : g_bad_cmd
      $error("command field does not fit the conversion");
   end

   logic                fall_evt;
   logic                rise_evt;
   logic [IDXW-1:0]     idx;
   logic [IDXW-1:0]     next_idx;
   logic                hold_start;
   phase_e              phase;
   logic [ADDR_W-1:0]   addr;
   logic [SAMPLE_W-1:0] sample_q;

   adcs_edge_det i_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .sclk     (sclk),
      .fall_evt (fall_evt),
      .rise_evt (rise_evt)
   );

   adcs_frame_seq #(
      .FRAME_LEN (FRAME_LEN),
      .TRACK_CYC (TRACK_CYC)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .fall_evt   (fall_evt),
      .idx        (idx),
      .next_idx   (next_idx),
      .hold_start (hold_start),
      .phase      (phase)
   );

   adcs_cmd_cap #(
      .CMD_W    (CMD_W),
      .ADDR_W   (ADDR_W),
      .ADDR_LSB (ADDR_LSB),
      .IDXW     (IDXW)
   ) i_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .rise_evt (rise_evt),
      .sdi      (sdi),
      .idx      (idx),
      .addr     (addr)
   );

   adcs_out_shift #(
      .NUM_CH    (NUM_CH),
      .SAMPLE_W  (SAMPLE_W),
      .FRAME_LEN (FRAME_LEN),
      .IDXW      (IDXW),
      .ADDR_W    (ADDR_W)
   ) i_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .fall_evt   (fall_evt),
      .hold_start (hold_start),
      .next_idx   (next_idx),
      .addr       (addr),
      .ch_data    (ch_data),
      .sample_q   (sample_q),
      .sdo        (sdo)
   );

   assign sdo_oe   = ~cs_n;
   assign track    = (phase == PH_TRACK);
   assign hold     = (phase == PH_HOLD);
   assign pwr_down = (phase == PH_OFF);
endmodule

// File: rtl/adcs_checker.sv
`timescale 1ns/1ps
module adcs_checker #(
   parameter int SAMPLE_W = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cs_n,
   input logic                sdo,
   input logic                sdo_oe,
   input logic                track,
   input logic                hold,
   input logic                pwr_down,
   input logic [SAMPLE_W-1:0] sample_q
);
   a_r6_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (pwr_down && !track && !hold && !sdo_oe));

   a_r2_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({track, hold, pwr_down}));

   a_r3_zero_while_tracking: assert property (@(posedge clk) disable iff (!rst_n)
      track |-> !sdo);

   a_r2_track_into_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(track) && !cs_n) |-> hold);

   a_r8_wake_not_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_down) |-> !hold);

   a_r9_sample_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && $past(hold)) |-> $stable(sample_q));
endmodule

bind mux_adc_serial_if adcs_checker #(.SAMPLE_W(SAMPLE_W)) i_adcs_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (cs_n),
   .sdo      (sdo),
   .sdo_oe   (sdo_oe),
   .track    (track),
   .hold     (hold),
   .pwr_down (pwr_down),
   .sample_q (sample_q)
);

// File: tb/test_mux_adc_serial_if.sv
`timescale 1ns/1ps
module test_mux_adc_serial_if;
   localparam int HALF = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b1;
   logic        sdi = 1'b0;
   logic [95:0] ch_data;
   logic        sdo, sdo_oe, track, hold, pwr_down;

   logic [11:0] chv [8];
   logic [7:0]  cmd_q [4];
   logic [2:0]  exp_addr;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   always_comb begin
      for (int i = 0; i < 8; i++) ch_data[i*12 +: 12] = chv[i];
   end

   mux_adc_serial_if i_mux_adc_serial_if (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .sclk     (sclk),
      .sdi      (sdi),
      .ch_data  (ch_data),
      .sdo      (sdo),
      .sdo_oe   (sdo_oe),
      .track    (track),
      .hold     (hold),
      .pwr_down (pwr_down)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wait_half();
      repeat (HALF) @(negedge clk);
   endtask

   // R11: outputs straight after reset.
   task automatic t_reset_state();
      check("R11 sdo", sdo, 0);
      check("R11 sdo_oe", sdo_oe, 0);
      check("R11 pwr_down", pwr_down, 1);
      check("R11 track", track, 0);
      check("R11 hold", hold, 0);
   endtask

   // One frame of nconv back-to-back conversions, commands taken from cmd_q.
   task automatic run_frame(input int nconv, input bit low_start);
      logic [15:0] word;
      logic [11:0] exp_smp;
      @(negedge clk);
      sclk = low_start ? 1'b0 : 1'b1;
      wait_half();
      cs_n = 1'b0;
      sdi = cmd_q[0][7];
      if (!low_start) begin
         wait_half();
         check("R7 wait track", track, 0);
         check("R7 wait hold", hold, 0);
         check("R7 wait pwr_down", pwr_down, 0);
         check("R7 wait sdo", sdo, 0);
         check("R6 sdo_oe selected", sdo_oe, 1);
      end
      for (int c = 0; c < nconv; c++) begin
         word = '0;
         exp_smp = '0;
         for (int k = 1; k <= 16; k++) begin
            if (!(c == 0 && k == 1 && low_start)) sclk = 1'b0;
            sdi = (k <= 8) ? cmd_q[c][8-k] : 1'b0;
            wait_half();
            check($sformatf("R2 track c%0d k%0d", c, k), track, (k <= 3) ? 1 : 0);
            check($sformatf("R2 hold c%0d k%0d", c, k), hold, (k >= 4 && k <= 15) ? 1 : 0);
            check($sformatf("R8 pwr_down c%0d k%0d", c, k), pwr_down, (k == 16) ? 1 : 0);
            if (k == 4) exp_smp = chv[exp_addr];
            if (k == 6) begin
               for (int i = 0; i < 8; i++) chv[i] = ~chv[i];
            end
            word = {word[14:0], sdo};
            sclk = 1'b1;
            wait_half();
            if (k == 8) exp_addr = cmd_q[c][5:3];
            if (k == 16) check("R8 pwr_down after rise 16", pwr_down, 1);
         end
         // R1 R3 R4 R5 R9: full serial word of this conversion
         check($sformatf("R3 R5 R9 word conv %0d", c), int'(word), int'({4'b0000, exp_smp}));
      end
      cs_n = 1'b1;
      wait_half();
      check("R6 sdo_oe deselected", sdo_oe, 0);
      check("R8 pwr_down deselected", pwr_down, 1);
   endtask

   // R10: command cut short by a select rise before rising edge 8.
   task automatic t_abort(input logic [7:0] cmd, input int nrise);
      @(negedge clk);
      sclk = 1'b1;
      wait_half();
      cs_n = 1'b0;
      wait_half();
      for (int k = 1; k <= nrise; k++) begin
         sclk = 1'b0;
         sdi = cmd[8-k];
         wait_half();
         sclk = 1'b1;
         wait_half();
      end
      cs_n = 1'b1;
      wait_half();
      check("R10 abort sdo_oe", sdo_oe, 0);
      check("R10 abort pwr_down", pwr_down, 1);
      check("R10 abort hold", hold, 0);
   endtask

   // R6: clock toggles while deselected leave every output idle.
   task automatic t_sclk_ignored();
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         sclk = ~sclk;
         sdi = ~sdi;
         wait_half();
         check("R6 ignored sdo_oe", sdo_oe, 0);
         check("R6 ignored pwr_down", pwr_down, 1);
         check("R6 ignored track", track, 0);
         check("R6 ignored sdo", sdo, 0);
      end
   endtask

   initial begin
      for (int i = 0; i < 8; i++) chv[i] = 12'hA5C ^ 12'(i * 12'h137);
      exp_addr = 3'd0;
      for (int i = 0; i < 4; i++) cmd_q[i] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();

      // R5: the first conversion uses channel 0, and its command selects channel 3.
      cmd_q[0] = 8'b00_011_000;
      run_frame(1, 1'b0);

      // R1 R4 R7: three conversions started with sclk low, ignored bits set.
      cmd_q[0] = 8'b11_110_111;
      cmd_q[1] = 8'b00_001_000;
      cmd_q[2] = 8'b01_111_010;
      run_frame(3, 1'b1);

      // R10: an aborted command toward channel 2 leaves channel 7 selected.
      t_abort(8'b00_010_000, 5);

      t_sclk_ignored();

      cmd_q[0] = 8'b10_000_101;
      cmd_q[1] = 8'b00_101_000;
      run_frame(2, 1'b0);
      cmd_q[0] = 8'h00;
      run_frame(1, 1'b1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule